// File: doc/BRIEF.md
# Oversampled Biphase-Mark Bit Recovery

This block turns an asynchronous biphase-mark coded audio line into decoded bits. It runs entirely on a fast, free-running sampling clock. Nominal rates are 72 MHz for streams up to 48 kHz and 144 MHz for 96 kHz. The line is synchronised with two flops, and every transition is timestamped. The block counts the clock cycles between consecutive transitions and compares that count with a running estimate of the half-cell width. Each interval is sorted into one, two or three half-cells, or rejected as invalid.

Two one-half intervals that close a bit cell produce a 1. A two-half interval that starts on a cell boundary produces a 0. A three-half interval is a coding violation, which marks a frame preamble; it is flagged so that downstream framing logic can align. A cell strobe pulses once per recovered bit cell, which gives 64 pulses per stereo frame (a 64-times-sample-rate bit clock).

Lock is declared once preambles arrive with the correct spacing for long enough. Lock is lost on silence or on an impossible interval. The half-cell estimate follows the incoming rate, so one fixed sampling clock covers a ±12.5 % pitch swing around 32, 44.1, 48 or 96 kHz. The decoded bit stream is valid-only. It has no ready and accepts no back-pressure, because the line cannot be paused: a consumer must take every beat in the cycle in which it is presented.

Top module: `bmr_rx`

## Requirements
- R1: After reset, `locked`, `dout_valid`, `cell_stb` and `pre_flag` are all 0.
- R2: The line is measured in sampling-clock cycles between transitions. The first transition after reset, or after a timeout, only starts a measurement and produces no output.
- R3: With half-cell estimate E and interval length L cycles, the interval is classified as follows: invalid if 2L < E or 2L ≥ 7E; one half-cell if 2L < 3E; two half-cells if 2L < 5E; otherwise three half-cells. With E = 8, an interval of 12 counts as two half-cells, 11 as one, and 27 as three.
- R4: E starts at `HALF_INIT`. Each one-half interval sets E to floor((E + L) / 2), and E changes at no other time. After four 11-cycle intervals from E = 8, a 12-cycle interval counts as one half-cell.
- R5: A one-half interval that completes a cell emits bit 1. A two-half interval that begins on a cell boundary emits bit 0. `dout_valid` is high for one cycle per bit, with the value on `dout_bit`, and no back-pressure is possible.
- R6: `cell_stb` pulses once for each completed bit cell (two half-cells), including cells inside preambles. When one interval completes two cells, the second pulse follows in the next cycle.
- R7: `pre_flag` pulses for one cycle for every three-half interval. No data bit is emitted for that interval.
- R8: A preamble start is a three-half interval preceded by at least 8 half-cells since the last three-half interval, or the first one after reset or loss of lock. A start is correctly spaced when exactly 64 half-cells separate it from the previous start. `locked` rises after `LOCK_N` (8) consecutive correctly spaced starts, which is the ninth preamble.
- R9: If no transition arrives within 4E cycles, lock is dropped, the lock count is cleared and cell alignment is reset.
- R10: An invalid interval, whether a glitch or an over-long gap, drops lock.
- R11: A wrongly spaced start clears the spacing count but does not drop a lock that is already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_serial | input | 1 | Asynchronous biphase-mark line |
| dout_valid | output | 1 | Decoded bit present this cycle |
| dout_bit | output | 1 | Decoded bit value |
| cell_stb | output | 1 | One pulse per recovered bit cell |
| pre_flag | output | 1 | Three-half-cell violation seen |
| locked | output | 1 | Preamble-spaced lock held |

## Verification
The classifier and decoder are driven with short transition patterns: runs of ones, runs of zeros, mixed words, and each of the three preamble shapes. These separate the bit values from the cell-strobe counts and the violation flags, and they cover odd half-cell alignment. Interval lengths placed just either side of a class boundary check the threshold comparisons. A run of 11-cycle halves followed by 12-cycle halves shows that the estimate adapts, because a fixed threshold would decode that same 12 as a 0. Full subframe sequences check when lock is gained, that a mis-spaced frame leaves an existing lock in place, and that silence, a 30-cycle gap and a 2-cycle glitch each remove lock.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  typedef enum logic [1:0] {
    IV_BAD   = 2'd0,
    IV_ONE   = 2'd1,
    IV_TWO   = 2'd2,
    IV_THREE = 2'd3
  } iv_class_e;
endpackage

// File: rtl/bmr_front.sv
// Line synchroniser, transition detect and interval counter with silence timeout.
module bmr_front #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [CNT_W-1:0] est,
  output logic             iv_valid,
  output logic [CNT_W-1:0] iv_len,
  output logic             tmo
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             s1, s2, s3, armed, edge_seen;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W+1:0] lim;

  assign lim       = {est, 2'b00};
  assign edge_seen = s2 ^ s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1       <= 1'b0;
      s2       <= 1'b0;
      s3       <= 1'b0;
      armed    <= 1'b0;
      cnt      <= '0;
      iv_valid <= 1'b0;
      iv_len   <= '0;
      tmo      <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
      if (edge_seen) begin
        armed    <= 1'b1;
        cnt      <= CNT_W'(1);
        iv_valid <= armed;
        iv_len   <= cnt;
        tmo      <= 1'b0;
      end else begin
        iv_valid <= 1'b0;
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (armed && ({2'b00, cnt} >= lim)) begin
          tmo   <= 1'b1;
          armed <= 1'b0;
        end else begin
          tmo <= 1'b0;
        end
      end
    end
  end

  AST_TMO_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !tmo) else $error("timeout repeated"); // R9
endmodule

// File: rtl/bmr_classify.sv
// Sorts intervals against the adaptive half-cell estimate and tracks that estimate.
module bmr_classify
  import bmr_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int HALF_INIT = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iv_valid,
  input  logic [CNT_W-1:0] iv_len,
  output logic             cls_valid,
  output iv_class_e        cls,
  output logic [CNT_W-1:0] est
);
  localparam int XW = CNT_W + 3;

  logic [XW-1:0] len2, e1, e3, e5, e7;
  logic [CNT_W:0] sum;
  iv_class_e      cls_d;

  assign len2 = XW'({iv_len, 1'b0});
  assign e1   = XW'(est);
  assign e3   = XW'(3) * e1;
  assign e5   = XW'(5) * e1;
  assign e7   = XW'(7) * e1;
  assign sum  = {1'b0, est} + {1'b0, iv_len};

  always_comb begin
    if (len2 < e1 || len2 >= e7) cls_d = IV_BAD;
    else if (len2 < e3)          cls_d = IV_ONE;
    else if (len2 < e5)          cls_d = IV_TWO;
    else                         cls_d = IV_THREE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_valid <= 1'b0;
      cls       <= IV_BAD;
      est       <= CNT_W'(HALF_INIT);
    end else begin
      cls_valid <= iv_valid;
      if (iv_valid) cls <= cls_d;
      if (iv_valid && cls_d == IV_ONE) est <= CNT_W'(sum >> 1);
    end
  end

  AST_EST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !iv_valid |=> $stable(est)) else $error("estimate moved without interval"); // R4
endmodule

// File: rtl/bmr_cells.sv
// Half-cell accounting: bit decode, cell strobe and violation flag.
module bmr_cells
  import bmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cls_valid,
  input  iv_class_e cls,
  input  logic      tmo,
  output logic      dout_valid,
  output logic      dout_bit,
  output logic      cell_stb,
  output logic      pre_flag
);
  logic       par, pend;
  logic [2:0] total;

  assign total = {2'b00, par} + {1'b0, cls};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par        <= 1'b0;
      pend       <= 1'b0;
      dout_valid <= 1'b0;
      dout_bit   <= 1'b0;
      cell_stb   <= 1'b0;
      pre_flag   <= 1'b0;
    end else begin
      dout_valid <= 1'b0;
      pre_flag   <= 1'b0;
      cell_stb   <= pend;
      pend       <= 1'b0;
      if (cls_valid) begin
        if (cls == IV_BAD) begin
          par <= 1'b0;
        end else begin
          par        <= total[0];
          cell_stb   <= (total[2:1] != 2'd0);
          pend       <= (total[2:1] == 2'd2);
          dout_valid <= (cls == IV_ONE && par) || (cls == IV_TWO && !par);
          dout_bit   <= (cls == IV_ONE);
          pre_flag   <= (cls == IV_THREE);
        end
      end else if (tmo) begin
        par <= 1'b0;
      end
    end
  end

  AST_BIT_ON_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> cell_stb) else $error("bit without cell strobe"); // R5
  AST_PRE_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    pre_flag |-> !dout_valid) else $error("bit during violation"); // R7
endmodule

// File: rtl/bmr_lock.sv
// Preamble spacing tracker and lock state.
module bmr_lock
  import bmr_pkg::*;
#(
  parameter int LOCK_N     = 8,
  parameter int SUB_HALVES = 64,
  parameter int PRE_GAP    = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cls_valid,
  input  iv_class_e cls,
  input  logic      tmo,
  output logic      locked
);
  localparam int HW = $clog2(PRE_GAP + 4) + 1;
  localparam int SW = $clog2(SUB_HALVES + 4) + 1;
  localparam int GW = $clog2(LOCK_N + 1);
  localparam logic [HW-1:0] HMAX = '1;
  localparam logic [SW-1:0] SMAX = '1;

  logic [HW-1:0] hsl, hsl_n;
  logic [SW-1:0] sp, sp_n;
  logic [GW-1:0] good;
  logic [HW:0]   hsl_sum;
  logic [SW:0]   sp_sum;
  logic          start;

  assign hsl_sum = {1'b0, hsl} + (HW+1)'(cls);
  assign sp_sum  = {1'b0, sp} + (SW+1)'(cls);
  assign hsl_n   = (hsl_sum > {1'b0, HMAX}) ? HMAX : hsl_sum[HW-1:0];
  assign sp_n    = (sp_sum > {1'b0, SMAX}) ? SMAX : sp_sum[SW-1:0];
  assign start   = (cls == IV_THREE) && (hsl >= HW'(PRE_GAP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsl    <= HMAX;
      sp     <= '0;
      good   <= '0;
      locked <= 1'b0;
    end else if (tmo || (cls_valid && cls == IV_BAD)) begin
      hsl    <= HMAX;
      sp     <= '0;
      good   <= '0;
      locked <= 1'b0;
    end else if (cls_valid) begin
      hsl <= (cls == IV_THREE) ? '0 : hsl_n;
      if (start) begin
        sp <= SW'(3);
        if (sp == SW'(SUB_HALVES)) begin
          if (good != GW'(LOCK_N)) good <= good + 1'b1;
          if (good == GW'(LOCK_N - 1)) locked <= 1'b1;
        end else begin
          good <= '0;
        end
      end else begin
        sp <= sp_n;
      end
    end
  end

  AST_TMO_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !locked) else $error("lock kept through silence"); // R9
  AST_BAD_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && cls == IV_BAD) |=> !locked) else $error("lock kept on bad interval"); // R10
  AST_LOCK_ON_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cls_valid && cls == IV_THREE)) else $error("lock without preamble"); // R8
endmodule

// File: rtl/bmr_rx.sv
module bmr_rx
  import bmr_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int HALF_INIT  = 12,
  parameter int LOCK_N     = 8,
  parameter int SUB_HALVES = 64,
  parameter int PRE_GAP    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_serial,
  output logic dout_valid,
  output logic dout_bit,
  output logic cell_stb,
  output logic pre_flag,
  output logic locked
);
  logic             iv_valid, tmo, cls_valid;
  logic [CNT_W-1:0] iv_len, est;
  iv_class_e        cls;

  bmr_front #(.CNT_W(CNT_W)) u_front (
    .clk(clk), .rst_n(rst_n), .din(din_serial), .est(est),
    .iv_valid(iv_valid), .iv_len(iv_len), .tmo(tmo)
  );

  bmr_classify #(.CNT_W(CNT_W), .HALF_INIT(HALF_INIT)) u_cls (
    .clk(clk), .rst_n(rst_n), .iv_valid(iv_valid), .iv_len(iv_len),
    .cls_valid(cls_valid), .cls(cls), .est(est)
  );

  bmr_cells u_cells (
    .clk(clk), .rst_n(rst_n), .cls_valid(cls_valid), .cls(cls), .tmo(tmo),
    .dout_valid(dout_valid), .dout_bit(dout_bit), .cell_stb(cell_stb), .pre_flag(pre_flag)
  );

  bmr_lock #(.LOCK_N(LOCK_N), .SUB_HALVES(SUB_HALVES), .PRE_GAP(PRE_GAP)) u_lock (
    .clk(clk), .rst_n(rst_n), .cls_valid(cls_valid), .cls(cls), .tmo(tmo), .locked(locked)
  );
endmodule

// File: tb/tb_bmr_rx.sv
module tb_bmr_rx;
  localparam int CLK_P = 10;
  localparam int H     = 8;
  localparam int NV    = 8;

  typedef struct packed {
    logic [3:0]  n;
    logic [15:0] codes;
    logic [3:0]  nbits;
    logic [7:0]  bits;
    logic [3:0]  nstb;
    logic [3:0]  npre;
  } vec_t;

  // codes: half-cell count of interval i at [2i+1:2i]; bits: first decoded bit in bit 0
  localparam vec_t VECS [NV] = '{
    '{4'd4, 16'h0055, 4'd2, 8'h03, 4'd2, 4'd0},
    '{4'd3, 16'h002A, 4'd3, 8'h00, 4'd3, 4'd0},
    '{4'd5, 16'h0165, 4'd3, 8'h05, 4'd3, 4'd0},
    '{4'd4, 16'h005F, 4'd1, 8'h01, 4'd4, 4'd2},
    '{4'd4, 16'h00D7, 4'd1, 8'h01, 4'd4, 4'd2},
    '{4'd4, 16'h009B, 4'd2, 8'h01, 4'd4, 4'd1},
    '{4'd6, 16'h0596, 4'd4, 8'h0A, 4'd4, 4'd0},
    '{4'd2, 16'h0009, 4'd0, 8'h00, 4'd1, 4'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, din = 1'b0;
  logic dout_valid, dout_bit, cell_stb, pre_flag, locked;
  int n_run = 0, n_fail = 0;
  int tot_bits = 0, tot_stb = 0, tot_pre = 0;
  logic bit_log [0:2047];
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bmr_rx #(.HALF_INIT(H)) dut (
    .clk(clk), .rst_n(rst_n), .din_serial(din),
    .dout_valid(dout_valid), .dout_bit(dout_bit),
    .cell_stb(cell_stb), .pre_flag(pre_flag), .locked(locked)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (dout_valid) begin
        if (tot_bits < 2048) bit_log[tot_bits] = dout_bit;
        tot_bits++;
      end
      if (cell_stb) tot_stb++;
      if (pre_flag) tot_pre++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_raw(input int n);
    din = ~din;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_iv(input int k);
    send_raw(k * H);
  endtask

  task automatic end_burst();
    din = ~din;
    repeat (50) @(negedge clk);
  endtask

  task automatic subframe(input int meds);
    send_iv(3); send_iv(3); send_iv(1); send_iv(1);
    for (int i = 0; i < meds; i++) send_iv(2);
  endtask

  task automatic acquire();
    for (int i = 0; i < 8; i++) subframe(28);
    send_iv(3); send_iv(3); send_iv(1);
  endtask

  function automatic int grab(input int b0, input int nb);
    int v = 0;
    for (int i = 0; i < nb; i++) v |= int'(bit_log[b0 + i]) << i;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int b0, s0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 locked", int'(locked), 0);
    chk("R1 dout_valid", int'(dout_valid), 0);
    chk("R1 cell_stb", int'(cell_stb), 0);
    chk("R1 pre_flag", int'(pre_flag), 0);

    // R2: a lone transition only arms the counter
    s0 = tot_stb; b0 = tot_bits; p0 = tot_pre;
    end_burst();
    chk("R2 lone edge output", (tot_stb - s0) + (tot_bits - b0) + (tot_pre - p0), 0);

    for (int v = 0; v < NV; v++) begin
      b0 = tot_bits; s0 = tot_stb; p0 = tot_pre;
      for (int i = 0; i < int'(VECS[v].n); i++) send_iv(int'(VECS[v].codes[2*i +: 2]));
      end_burst();
      chk("R5 bit count", tot_bits - b0, int'(VECS[v].nbits));
      chk("R5 bit values", grab(b0, tot_bits - b0), int'(VECS[v].bits));
      chk("R6 cell strobes", tot_stb - s0, int'(VECS[v].nstb));
      chk("R7 violations", tot_pre - p0, int'(VECS[v].npre));
    end

    // R3 lower boundary: 12 cycles at E=8 is a two-half zero
    b0 = tot_bits;
    send_raw(12); send_raw(8); send_raw(8);
    end_burst();
    chk("R3 boundary bits", grab(b0, tot_bits - b0) | ((tot_bits - b0) << 8), 2 | (2 << 8));
    // R3 upper boundary: 27 cycles is still a violation, not invalid
    p0 = tot_pre;
    send_raw(27);
    end_burst();
    chk("R3 27-cycle violation", tot_pre - p0, 1);

    // R8 acquisition on the ninth preamble
    for (int i = 0; i < 8; i++) subframe(28);
    send_iv(3);
    chk("R8 not yet locked", int'(locked), 0);
    send_iv(3);
    chk("R8 locked", int'(locked), 1);
    send_iv(1); send_iv(1);
    for (int i = 0; i < 28; i++) send_iv(2);
    subframe(27);
    send_iv(3); send_iv(3);
    chk("R11 lock held on misspacing", int'(locked), 1);
    repeat (30) @(negedge clk);
    chk("R9 silence unlocks", int'(locked), 0);

    // R10 over-long gap
    acquire();
    chk("R8 reacquired", int'(locked), 1);
    send_raw(30);
    din = ~din;
    repeat (10) @(negedge clk);
    chk("R10 long gap unlocks", int'(locked), 0);
    repeat (50) @(negedge clk);

    // R10 glitch
    acquire();
    chk("R8 reacquired again", int'(locked), 1);
    send_raw(2);
    din = ~din;
    repeat (10) @(negedge clk);
    chk("R10 glitch unlocks", int'(locked), 0);
    repeat (50) @(negedge clk);

    // R4 adaptive estimate: 12-cycle halves decode as ones after 11-cycle halves
    b0 = tot_bits;
    for (int i = 0; i < 4; i++) send_raw(11);
    send_raw(12); send_raw(12);
    end_burst();
    chk("R4 adapted bit count", tot_bits - b0, 3);
    chk("R4 adapted bit values", grab(b0, tot_bits - b0), 7);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule